// File: doc/BRIEF.md
# Memory Power-Down Sequencer

This block sits between a memory controller and a low-power DDR memory. It owns the clock-enable pin and the command pins. Ordinary controller commands pass through it, and it registers each one onto the bus. On request, it takes the memory into power-down or into deep power-down and brings it back out, applying the memory's timing rules on both edges of each transition.

The sequencer watches the activate and precharge commands that it forwards, so it always knows whether every bank is closed. It will only enter deep power-down when every bank is closed. Leaving deep power-down loses the memory contents. After that exit the block waits a fixed settling time, counted in controller clocks. It then asks an external initialization engine to run, and only that engine's commands reach the bus until the engine reports completion.

Top module: `pd_sequencer`

## Requirements
- R1: A host command that is accepted appears on the bus one cycle later. The pins cs_n, ras_n, cas_n and we_n take these values: activate 0011, read 0101, write 0100, precharge 0010, precharge-all 0010 with ap=1, refresh 0001, mode-register set 0000, no-op 0111. The ba pins take the command's bank. The hc_op codes are: 0 activate, 1 read, 2 write, 3 precharge, 4 precharge-all, 5 refresh, 6 mode-register set, 7 no-op.
- R2: hc_ready is high only in the active state, or in the initialization state when hc_init is high. A command offered while hc_ready is low leaves the bus at no-op.
- R3: In the active state, when hc_valid is low and dpd_req is low, pd_req drops cke on the next edge and pulses pd_ack. A valid host command wins over dpd_req, and dpd_req wins over pd_req.
- R4: wake_req is accepted only after cke has been low for TCKE_CYC (default 2) cycles. Until then it is ignored, and the request may stay high.
- R5: After cke rises out of power-down, the first host command can reach the bus no earlier than TXP_CYC (default 2, minimum 2) cycles later.
- R6: dpd_req is accepted only when no bank is open. A bank opens on activate and closes on precharge of that bank or on precharge-all. On acceptance, cke drops and the burst-terminate code 0110 is driven on the same edge, and dpd_ack pulses. If any bank is open, dpd_nak pulses and nothing else changes.
- R7: Waking from deep power-down raises cke with only a no-op on the bus and sets mem_lost. init_req rises exactly CLK_MHZ*INIT_US cycles after cke rises.
- R8: init_req stays high until init_done is seen. The block then returns to active and init_req clears.
- R9: While cke is low, the bus carries only no-op, except for the burst-terminate on the edge that enters deep power-down. The bus also carries only no-op during both exit waits.
- R10: dev_status reports 0 active, 1 power-down (including its exit wait), 2 deep power-down, 3 re-initialization (the settling wait and the init handshake).
- R11: mem_lost stays set until the first write command is issued.
- R12: After reset: cke is 1, the bus is no-op, dev_status is 0, hc_ready is 1, and all acknowledges, init_req and mem_lost are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| hc_valid | input | 1 | Host command offered |
| hc_op | input | 3 | Host command code |
| hc_bank | input | BW | Host command bank |
| hc_init | input | 1 | Command comes from the initialization engine |
| hc_ready | output | 1 | Host command accepted this cycle if valid |
| pd_req | input | 1 | Request power-down |
| dpd_req | input | 1 | Request deep power-down |
| wake_req | input | 1 | Request exit from either low-power state |
| init_done | input | 1 | Initialization engine finished |
| pd_ack | output | 1 | Power-down entered (pulse) |
| dpd_ack | output | 1 | Deep power-down entered (pulse) |
| dpd_nak | output | 1 | Deep power-down refused, bank open (pulse) |
| wake_ack | output | 1 | Exit started (pulse) |
| init_req | output | 1 | Re-initialization requested |
| mem_lost | output | 1 | Memory contents are invalid |
| dev_status | output | 2 | Device state code |
| cke | output | 1 | Clock enable to memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BW | Bank address |
| ap | output | 1 | All-bank precharge flag (address bit 10) |

## Verification
A bank tracker that misses an activate or a precharge shows up when a deep power-down request is answered. The bench sees a wrong ack-or-nak pulse one cycle after the request, together with a cke that should not have changed. A timer that is off by one cycle moves the wake acknowledge, the first command after an exit, or the rise of init_req by exactly one clock. Because the bench compares every output on every cycle against its model, a wrong state is reported in the first cycle that it touches a pin.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

    typedef enum logic [2:0] {
        OP_ACT  = 3'd0,
        OP_RD   = 3'd1,
        OP_WR   = 3'd2,
        OP_PRE  = 3'd3,
        OP_PREA = 3'd4,
        OP_REF  = 3'd5,
        OP_MRS  = 3'd6,
        OP_NOP  = 3'd7
    } hc_op_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    localparam pins_t PINS_NOP = 4'b0111;
    localparam pins_t PINS_BST = 4'b0110;

    typedef enum logic [2:0] {
        ST_ACT  = 3'd0,
        ST_PD   = 3'd1,
        ST_PDX  = 3'd2,
        ST_DPD  = 3'd3,
        ST_DPDX = 3'd4,
        ST_INIT = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        STS_ACTIVE = 2'd0,
        STS_PD     = 2'd1,
        STS_DPD    = 2'd2,
        STS_REINIT = 2'd3
    } dev_status_e;

    function automatic pins_t op_pins(hc_op_e op);
        case (op)
            OP_ACT:  return 4'b0011;
            OP_RD:   return 4'b0101;
            OP_WR:   return 4'b0100;
            OP_PRE:  return 4'b0010;
            OP_PREA: return 4'b0010;
            OP_REF:  return 4'b0001;
            OP_MRS:  return 4'b0000;
            default: return PINS_NOP;
        endcase
    endfunction

    function automatic dev_status_e status_of(seq_state_e s);
        case (s)
            ST_ACT:          return STS_ACTIVE;
            ST_PD, ST_PDX:   return STS_PD;
            ST_DPD:          return STS_DPD;
            default:         return STS_REINIT;
        endcase
    endfunction

    function automatic int imax3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/pdseq_timer.sv
module pdseq_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic [TW-1:0] val,
    output logic          zero
);
    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - TW'(1);
        end
    end

    assign val  = cnt_q;
    assign zero = (cnt_q == '0);

    // the count never moves up except through a load
    assert_timer_down_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(load) && $past(cnt_q) != '0 |-> cnt_q == $past(cnt_q) - TW'(1));
endmodule

// File: rtl/pdseq_bank_track.sv
module pdseq_bank_track
    import pdseq_pkg::*;
#(
    parameter int NBANK = 4,
    localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          upd,
    input  hc_op_e        op,
    input  logic [BW-1:0] bank,
    output logic [NBANK-1:0] open_mask,
    output logic          all_idle
);
    logic [NBANK-1:0] open_q;

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        logic hit;
        assign hit = (bank == BW'(b));
        always_ff @(posedge clk) begin
            if (rst) begin
                open_q[b] <= 1'b0;
            end else if (upd) begin
                if (op == OP_PREA)
                    open_q[b] <= 1'b0;
                else if (hit && op == OP_ACT)
                    open_q[b] <= 1'b1;
                else if (hit && op == OP_PRE)
                    open_q[b] <= 1'b0;
            end
        end
    end

    assign open_mask = open_q;
    assign all_idle  = (open_q == '0);

    assert_prea_closes_all_R6: assert property (@(posedge clk) disable iff (rst)
        (upd && op == OP_PREA) |=> all_idle);
    assert_act_opens_R6: assert property (@(posedge clk) disable iff (rst)
        (upd && op == OP_ACT) |=> !all_idle);
endmodule

// File: rtl/pd_sequencer.sv
module pd_sequencer
    import pdseq_pkg::*;
#(
    parameter int NBANK    = 4,
    parameter int CLK_MHZ  = 250,
    parameter int INIT_US  = 200,
    parameter int TCKE_CYC = 2,
    parameter int TXP_CYC  = 2,
    localparam int BW = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hc_valid,
    input  logic [2:0]    hc_op,
    input  logic [BW-1:0] hc_bank,
    input  logic          hc_init,
    output logic          hc_ready,
    input  logic          pd_req,
    input  logic          dpd_req,
    input  logic          wake_req,
    input  logic          init_done,
    output logic          pd_ack,
    output logic          dpd_ack,
    output logic          dpd_nak,
    output logic          wake_ack,
    output logic          init_req,
    output logic          mem_lost,
    output logic [1:0]    dev_status,
    output logic          cke,
    output logic          cs_n,
    output logic          ras_n,
    output logic          cas_n,
    output logic          we_n,
    output logic [BW-1:0] ba,
    output logic          ap
);
    localparam int INIT_CYC = CLK_MHZ * INIT_US;
    localparam int TMAX     = imax3(INIT_CYC, TCKE_CYC, TXP_CYC);
    localparam int TW       = $clog2(TMAX + 1);

    seq_state_e    st_q, st_d;
    hc_op_e        op;
    logic          fire, act_free, dpd_try, dpd_ok, dpd_bad, pd_go, wake_go;
    logic          in_low, pdx_done, dpdx_done, init_fin;
    logic          tmr_load, tmr_zero;
    logic [TW-1:0] tmr_ld_val, tmr_val;
    logic          all_idle;
    logic [NBANK-1:0] open_mask;

    logic          cke_q, ap_q, init_req_q, lost_q;
    logic          pd_ack_q, dpd_ack_q, dpd_nak_q, wake_ack_q;
    pins_t         pins_q;
    logic [BW-1:0] ba_q;

    assign op       = hc_op_e'(hc_op);
    assign hc_ready = (st_q == ST_ACT) || (st_q == ST_INIT && hc_init);
    assign fire     = hc_valid && hc_ready;

    // priority in the active state: host command, then deep, then plain
    assign act_free = (st_q == ST_ACT) && !hc_valid;
    assign dpd_try  = act_free && dpd_req;
    assign dpd_ok   = dpd_try && all_idle;
    assign dpd_bad  = dpd_try && !all_idle;
    assign pd_go    = act_free && !dpd_req && pd_req;

    assign in_low    = (st_q == ST_PD) || (st_q == ST_DPD);
    assign wake_go   = in_low && wake_req && tmr_zero;
    assign pdx_done  = (st_q == ST_PDX) && (tmr_val == TW'(1));
    assign dpdx_done = (st_q == ST_DPDX) && tmr_zero;
    assign init_fin  = (st_q == ST_INIT) && init_done;

    always_comb begin
        tmr_load   = 1'b0;
        tmr_ld_val = '0;
        if (pd_go || dpd_ok) begin
            tmr_load   = 1'b1;
            tmr_ld_val = TW'(TCKE_CYC - 1);
        end else if (wake_go) begin
            tmr_load   = 1'b1;
            tmr_ld_val = (st_q == ST_PD) ? TW'(TXP_CYC - 1) : TW'(INIT_CYC - 1);
        end
    end

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_ACT:  if (dpd_ok) st_d = ST_DPD; else if (pd_go) st_d = ST_PD;
            ST_PD:   if (wake_go) st_d = ST_PDX;
            ST_PDX:  if (pdx_done) st_d = ST_ACT;
            ST_DPD:  if (wake_go) st_d = ST_DPDX;
            ST_DPDX: if (dpdx_done) st_d = ST_INIT;
            ST_INIT: if (init_fin) st_d = ST_ACT;
            default: st_d = ST_ACT;
        endcase
    end

    pdseq_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_ld_val),
        .val      (tmr_val),
        .zero     (tmr_zero)
    );

    pdseq_bank_track #(.NBANK(NBANK)) u_banks (
        .clk       (clk),
        .rst       (rst),
        .upd       (fire),
        .op        (op),
        .bank      (hc_bank),
        .open_mask (open_mask),
        .all_idle  (all_idle)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_ACT;
            cke_q      <= 1'b1;
            pins_q     <= PINS_NOP;
            ba_q       <= '0;
            ap_q       <= 1'b0;
            init_req_q <= 1'b0;
            lost_q     <= 1'b0;
            pd_ack_q   <= 1'b0;
            dpd_ack_q  <= 1'b0;
            dpd_nak_q  <= 1'b0;
            wake_ack_q <= 1'b0;
        end else begin
            st_q       <= st_d;
            pins_q     <= PINS_NOP;
            ap_q       <= 1'b0;
            pd_ack_q   <= pd_go;
            dpd_ack_q  <= dpd_ok;
            dpd_nak_q  <= dpd_bad;
            wake_ack_q <= wake_go;
            if (fire) begin
                pins_q <= op_pins(op);
                ba_q   <= hc_bank;
                ap_q   <= (op == OP_PREA);
            end
            if (pd_go || dpd_ok)
                cke_q <= 1'b0;
            if (dpd_ok)
                pins_q <= PINS_BST;
            if (wake_go)
                cke_q <= 1'b1;
            if (wake_go && st_q == ST_DPD)
                lost_q <= 1'b1;
            else if (fire && op == OP_WR)
                lost_q <= 1'b0;
            if (dpdx_done)
                init_req_q <= 1'b1;
            else if (init_fin)
                init_req_q <= 1'b0;
        end
    end

    assign cke        = cke_q;
    assign cs_n       = pins_q.cs_n;
    assign ras_n      = pins_q.ras_n;
    assign cas_n      = pins_q.cas_n;
    assign we_n       = pins_q.we_n;
    assign ba         = ba_q;
    assign ap         = ap_q;
    assign init_req   = init_req_q;
    assign mem_lost   = lost_q;
    assign pd_ack     = pd_ack_q;
    assign dpd_ack    = dpd_ack_q;
    assign dpd_nak    = dpd_nak_q;
    assign wake_ack   = wake_ack_q;
    assign dev_status = status_of(st_q);

    initial begin
        assert_txp_min_R5: assert (TXP_CYC >= 2 && TCKE_CYC >= 1 && INIT_CYC >= 1);
    end

    assert_quiet_low_R9: assert property (@(posedge clk) disable iff (rst)
        (!cke_q && !(pins_q == PINS_BST && $fell(cke_q))) |-> pins_q == PINS_NOP);

    assert_cke_min_low_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(cke_q) |-> !$past(cke_q, 2));

    assert_exit_gap_R5: assert property (@(posedge clk) disable iff (rst)
        (cke_q && pins_q != PINS_NOP) |-> ($past(cke_q) && $past(cke_q, 2)));

    assert_dpd_banks_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (pins_q == PINS_BST && !cke_q) |-> $past(all_idle));

    assert_init_release_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(init_req_q) |-> $past(init_done));

    assert_wake_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(cke_q) |-> pins_q == PINS_NOP);

    assert_acks_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pd_ack_q, dpd_ack_q, dpd_nak_q, wake_ack_q}));
endmodule

// File: tb/tb_pd_sequencer.sv
module tb_pd_sequencer;
    localparam int NBANK = 4;
    localparam int BW = 2;
    localparam int CLK_MHZ = 1;
    localparam int INIT_US = 200;
    localparam int TCKE = 2;
    localparam int TXP = 2;
    localparam int INIT_CYC = CLK_MHZ * INIT_US;
    localparam logic [3:0] NOP = 4'b0111;
    localparam logic [3:0] BST = 4'b0110;

    logic clk = 0, rst = 1;
    logic hc_valid = 0, hc_init = 0, pd_req = 0, dpd_req = 0, wake_req = 0, init_done = 0;
    logic [2:0] hc_op = 3'd7;
    logic [BW-1:0] hc_bank = '0;
    logic hc_ready, pd_ack, dpd_ack, dpd_nak, wake_ack, init_req, mem_lost, cke;
    logic cs_n, ras_n, cas_n, we_n, ap;
    logic [1:0] dev_status;
    logic [BW-1:0] ba;

    int n_chk = 0, n_fail = 0, cycles = 0;

    always #2 clk = ~clk;

    pd_sequencer #(.NBANK(NBANK), .CLK_MHZ(CLK_MHZ), .INIT_US(INIT_US),
                   .TCKE_CYC(TCKE), .TXP_CYC(TXP)) dut (
        .clk(clk), .rst(rst), .hc_valid(hc_valid), .hc_op(hc_op), .hc_bank(hc_bank),
        .hc_init(hc_init), .hc_ready(hc_ready), .pd_req(pd_req), .dpd_req(dpd_req),
        .wake_req(wake_req), .init_done(init_done), .pd_ack(pd_ack), .dpd_ack(dpd_ack),
        .dpd_nak(dpd_nak), .wake_ack(wake_ack), .init_req(init_req), .mem_lost(mem_lost),
        .dev_status(dev_status), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .ap(ap));

    // behavioural model: 0 act, 1 pd, 2 pd-exit, 3 dpd, 4 dpd-exit, 5 init
    int m_st, m_cnt;
    bit m_cke, m_ap, m_lost, m_ireq;
    logic [3:0] m_pins;
    logic [3:0] m_acks;  // pd, dpd, nak, wake
    int m_ba;
    bit m_open [NBANK];

    function automatic logic [3:0] pins_of(int op);
        case (op)
            0: return 4'b0011;
            1: return 4'b0101;
            2: return 4'b0100;
            3: return 4'b0010;
            4: return 4'b0010;
            5: return 4'b0001;
            6: return 4'b0000;
            default: return NOP;
        endcase
    endfunction

    function automatic bit none_open();
        foreach (m_open[i]) if (m_open[i]) return 0;
        return 1;
    endfunction

    function automatic bit m_ready();
        return (m_st == 0) || (m_st == 5 && hc_init);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_cnt = 0; m_cke = 1; m_pins = NOP; m_ba = 0; m_ap = 0;
            m_lost = 0; m_ireq = 0; m_acks = 0;
            foreach (m_open[i]) m_open[i] = 0;
        end else begin
            automatic int nst = m_st;
            automatic int ncnt = (m_cnt > 0) ? m_cnt - 1 : 0;
            automatic bit rdy = m_ready();
            automatic bit idle = none_open();
            m_pins = NOP; m_ap = 0; m_acks = 0;
            if (hc_valid && rdy) begin
                m_pins = pins_of(int'(hc_op));
                m_ba = int'(hc_bank);
                m_ap = (hc_op == 3'd4);
                if (hc_op == 3'd0) m_open[hc_bank] = 1;
                if (hc_op == 3'd3) m_open[hc_bank] = 0;
                if (hc_op == 3'd4) foreach (m_open[i]) m_open[i] = 0;
                if (hc_op == 3'd2) m_lost = 0;
            end
            case (m_st)
                0: if (!hc_valid) begin
                    if (dpd_req) begin
                        if (idle) begin
                            m_cke = 0; m_pins = BST; nst = 3; ncnt = TCKE - 1; m_acks = 4'b0100;
                        end else m_acks = 4'b0010;
                    end else if (pd_req) begin
                        m_cke = 0; nst = 1; ncnt = TCKE - 1; m_acks = 4'b1000;
                    end
                end
                1, 3: if (wake_req && m_cnt == 0) begin
                    m_cke = 1; m_acks = 4'b0001;
                    if (m_st == 1) begin nst = 2; ncnt = TXP - 1; end
                    else begin nst = 4; ncnt = INIT_CYC - 1; m_lost = 1; end
                end
                2: if (m_cnt == 1) nst = 0;
                4: if (m_cnt == 0) begin nst = 5; m_ireq = 1; end
                5: if (init_done) begin nst = 0; m_ireq = 0; end
                default: ;
            endcase
            m_st = nst; m_cnt = ncnt;
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", req, cycles, act, exp);
        end
    endtask

    function automatic int m_status();
        case (m_st)
            0: return 0;
            1, 2: return 1;
            3: return 2;
            default: return 3;
        endcase
    endfunction

    // compare at the falling edge, inputs change just after the rising edge
    always @(negedge clk) begin
        if (!rst) begin
            automatic logic [3:0] p = {cs_n, ras_n, cas_n, we_n};
            chk(cke == m_cke, "R4/R5/R6/R7 cke", cke, m_cke);
            chk(p == m_pins, "R1/R6/R9 command pins", p, m_pins);
            if (m_pins != NOP && m_pins != BST) begin
                chk(int'(ba) == m_ba, "R1 bank", ba, m_ba);
                chk(ap == m_ap, "R1 ap", ap, m_ap);
            end
            chk(hc_ready == m_ready(), "R2 hc_ready", hc_ready, m_ready());
            chk({pd_ack, dpd_ack, dpd_nak, wake_ack} == m_acks, "R3/R6 acks",
                {pd_ack, dpd_ack, dpd_nak, wake_ack}, m_acks);
            chk(int'(dev_status) == m_status(), "R10 status", dev_status, m_status());
            chk(init_req == m_ireq, "R7/R8 init_req", init_req, m_ireq);
            chk(mem_lost == m_lost, "R11 mem_lost", mem_lost, m_lost);
        end
    end

    task automatic cyc(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic cmd(int op, int bank, bit from_init = 0);
        hc_valid = 1; hc_op = 3'(op); hc_bank = BW'(bank); hc_init = from_init;
        cyc();
        hc_valid = 0; hc_op = 3'd7; hc_init = 0;
    endtask

    task automatic wait_wake();
        wake_req = 1;
        for (int i = 0; i < 50 && !wake_ack; i++) cyc();
        wake_req = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        cyc(3);
        rst = 0;
        cyc(2);                                   // R12 reset state compared by model
        chk(cke && hc_ready && dev_status == 0, "R12 reset", {cke, hc_ready}, 2'b11);
        cmd(0, 0); cmd(0, 2); cmd(1, 2); cmd(2, 0);
        dpd_req = 1; cyc(); dpd_req = 0; cyc(2);  // R6 refused with banks open
        pd_req = 1; hc_valid = 1; hc_op = 3'd5; cyc(); // R3 host wins
        hc_valid = 0; cyc(); pd_req = 0; cyc();
        wake_req = 1; cyc(4); wake_req = 0;       // R4 early wake held
        cmd(1, 0);                                // R5 first command after exit
        cyc(2);
        pd_req = 1; dpd_req = 1; cyc(); pd_req = 0; dpd_req = 0; cyc(); // R3 nak wins over pd
        cmd(3, 0); cmd(4, 1);                     // R6 close all
        dpd_req = 1; cyc(); dpd_req = 0; cyc(3);
        wait_wake();                              // R7
        cmd(6, 0, 0);                             // R2 dropped during wait
        cyc(INIT_CYC + 2);
        cmd(1, 1, 0);                             // R2 not ready in init without hc_init
        cmd(6, 0, 1); cmd(5, 0, 1);               // init engine commands
        init_done = 1; cyc(); init_done = 0; cyc(2); // R8
        cmd(1, 3); cmd(2, 3);                     // R11 write clears lost
        // random phase
        for (int i = 0; i < 4000; i++) begin
            hc_valid = ($urandom_range(0, 9) < 3);
            hc_op = 3'($urandom_range(0, 7));
            hc_bank = BW'($urandom_range(0, NBANK - 1));
            hc_init = $urandom_range(0, 1);
            pd_req = ($urandom_range(0, 19) == 0);
            dpd_req = ($urandom_range(0, 14) == 0);
            wake_req = ($urandom_range(0, 4) == 0);
            init_done = ($urandom_range(0, 9) == 0);
            cyc();
        end
        hc_valid = 0; pd_req = 0; dpd_req = 0; wake_req = 0; init_done = 0;
        cyc(3);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule